// File: doc/BRIEF.md
# Pipelined Complex Multiply-Accumulate Unit

This block multiplies two complex numbers, each supplied as a signed real part and a signed imaginary part. It uses four real multipliers and two adders to form the full-precision product. It can return that product on its own, or fold it into a running complex total.

The datapath has three register stages. The first registers the operands, the second registers the four partial products, and the third is the accumulator, which holds the adder outputs. A valid flag travels alongside the data through the same stages. A clear input restarts the running total. An accumulate-enable input chooses between summing and passing the bare product through. Every register uses a synchronous reset.

Each result part is twice the operand width plus one bit wide, so no product bit is lost. The running total wraps around on overflow and never saturates.

Top module: `cplx_mac`

## Requirements
- R1: Operands are two's-complement. The real result is aRe*bRe − aIm*bIm and the imaginary result is aRe*bIm + aIm*bRe. Both are exact in RES_W = 2*OP_W+1 bits, and the four partial products are sign-extended before they are added.
- R2: An input sampled with inValid high on rising edge k appears on the result ports with outValid high right after rising edge k+2, the third edge counting edge k. outValid is always inValid delayed by three clock cycles.
- R3: While rst is high at a rising edge, every register clears. After that edge outValid is 0, resRe is 0 and resIm is 0.
- R4: accClear and accEnable are sampled in the same cycle as the operands. For a valid input with accEnable low and accClear low, the result equals the bare product of that input.
- R5: For a valid input with accEnable high and accClear low, the result equals the previous total plus the product of that input.
- R6: For a valid input with accClear high, the total is loaded with that input's product, whatever the value of accEnable.
- R7: accClear high with inValid low sets the total to zero. The zero shows on resRe and resIm three cycles later, with outValid low.
- R8: The total wraps modulo 2^RES_W on overflow, with no saturation.
- R9: When neither a valid input nor a clear reaches the last stage, resRe and resIm keep their values and outValid is low.
- R10: The most negative operand value is exact in both parts. With all four operand parts at −2^(OP_W−1), the real result is 0 and the imaginary result is 2^(2*OP_W−1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Marks the operands and controls this cycle as valid |
| aRe | input | OP_W | Operand A, real part, signed |
| aIm | input | OP_W | Operand A, imaginary part, signed |
| bRe | input | OP_W | Operand B, real part, signed |
| bIm | input | OP_W | Operand B, imaginary part, signed |
| accClear | input | 1 | Restart the total (load on valid, zero otherwise) |
| accEnable | input | 1 | Add the product into the total when high |
| outValid | output | 1 | Result ports carry a new result |
| resRe | output | 2*OP_W+1 | Result or total, real part, signed |
| resIm | output | 2*OP_W+1 | Result or total, imaginary part, signed |

## Verification
A fault in the valid chain or in the control pipeline shows within three cycles of the stimulus. It appears as a misplaced outValid, or as a result tied to the wrong input's control bits. A corrupted accumulator value does not fade away: it persists on the result ports for every later accumulating input until the next clear or unaccumulated load. A wrong sign-extension or wrong lane pairing shows on the first valid product involving negative or extreme operands. The run therefore leans on the most negative value and on long accumulation chains that wrap.

// File: rtl/cplx_mac_pkg.sv
package cplx_mac_pkg;

  // Strobes from the control pipeline to the datapath, one set per cycle.
  typedef struct packed {
    logic ld1;      // capture operands
    logic ld2;      // capture partial products
    logic accLoad;  // total <= product
    logic accAdd;   // total <= total + product
    logic accZero;  // total <= 0
  } macStrobe_t;

endpackage

// File: rtl/cplx_mac_ctrl.sv
module cplx_mac_ctrl
  import cplx_mac_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic       accClear,
  input  logic       accEnable,
  output macStrobe_t strobe,
  output logic       outValid
);

  logic vld1, vld2, vld3;
  logic clr1, clr2;
  logic en1, en2;

  // Control bits ride alongside the data, one register per datapath stage.
  always_ff @(posedge clk) begin
    if (rst) begin
      vld1 <= 1'b0;
      vld2 <= 1'b0;
      vld3 <= 1'b0;
      clr1 <= 1'b0;
      clr2 <= 1'b0;
      en1  <= 1'b0;
      en2  <= 1'b0;
    end else begin
      vld1 <= inValid;
      vld2 <= vld1;
      vld3 <= vld2;
      clr1 <= accClear;
      clr2 <= clr1;
      en1  <= accEnable;
      en2  <= en1;
    end
  end

  always_comb begin
    strobe.ld1     = inValid;
    strobe.ld2     = vld1;
    strobe.accLoad = vld2 && (clr2 || !en2);
    strobe.accAdd  = vld2 && !clr2 && en2;
    strobe.accZero = !vld2 && clr2;
  end

  assign outValid = vld3;

  // Cycles since reset, saturating; gates the latency check below.
  logic [1:0] ageQ;
  always_ff @(posedge clk) begin
    if (rst)                ageQ <= 2'd0;
    else if (ageQ != 2'd3)  ageQ <= ageQ + 2'd1;
  end

  AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (ageQ == 2'd3) |-> (outValid == $past(inValid, 3))); // R2

endmodule

// File: rtl/cplx_mac_dp.sv
module cplx_mac_dp
  import cplx_mac_pkg::*;
#(
  parameter  int OP_W  = 18,
  localparam int RES_W = 2 * OP_W + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  macStrobe_t              strobe,
  input  logic signed [OP_W-1:0]  aRe,
  input  logic signed [OP_W-1:0]  aIm,
  input  logic signed [OP_W-1:0]  bRe,
  input  logic signed [OP_W-1:0]  bIm,
  output logic signed [RES_W-1:0] resRe,
  output logic signed [RES_W-1:0] resIm
);

  localparam int PROD_W = 2 * OP_W;
  localparam int LANES  = 4;
  localparam int EXT_W  = RES_W - PROD_W;

  // Stage 1: operand registers.
  logic signed [OP_W-1:0] aReQ, aImQ, bReQ, bImQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      aReQ <= '0;
      aImQ <= '0;
      bReQ <= '0;
      bImQ <= '0;
    end else if (strobe.ld1) begin
      aReQ <= aRe;
      aImQ <= aIm;
      bReQ <= bRe;
      bImQ <= bIm;
    end
  end

  // Lane order: 0 re*re, 1 im*im, 2 re*im, 3 im*re.
  logic signed [OP_W-1:0] mulA [LANES];
  logic signed [OP_W-1:0] mulB [LANES];

  always_comb begin
    mulA[0] = aReQ;  mulB[0] = bReQ;
    mulA[1] = aImQ;  mulB[1] = bImQ;
    mulA[2] = aReQ;  mulB[2] = bImQ;
    mulA[3] = aImQ;  mulB[3] = bReQ;
  end

  // Stage 2: partial product registers.
  logic signed [PROD_W-1:0] prodQ [LANES];

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (rst)             prodQ[i] <= '0;
      else if (strobe.ld2) prodQ[i] <= mulA[i] * mulB[i];
    end
  end

  // Sign-extend each product to the result width before combining.
  logic signed [RES_W-1:0] prodExt [LANES];

  always_comb begin
    for (int i = 0; i < LANES; i++)
      prodExt[i] = {{EXT_W{prodQ[i][PROD_W-1]}}, prodQ[i]};
  end

  logic signed [RES_W-1:0] sumRe, sumIm;
  assign sumRe = prodExt[0] - prodExt[1];
  assign sumIm = prodExt[2] + prodExt[3];

  // Stage 3: adder-output register doubling as the running total.
  logic signed [RES_W-1:0] accRe, accIm;

  always_ff @(posedge clk) begin
    if (rst) begin
      accRe <= '0;
      accIm <= '0;
    end else if (strobe.accZero) begin
      accRe <= '0;
      accIm <= '0;
    end else if (strobe.accLoad) begin
      accRe <= sumRe;
      accIm <= sumIm;
    end else if (strobe.accAdd) begin
      accRe <= accRe + sumRe;   // wraps modulo 2^RES_W
      accIm <= accIm + sumIm;
    end
  end

  assign resRe = accRe;
  assign resIm = accIm;

  AST_ZERO_ON_CLEAR: assert property (@(posedge clk) disable iff (rst)
    strobe.accZero |=> (accRe == '0 && accIm == '0)); // R7

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !(strobe.accZero || strobe.accLoad || strobe.accAdd)
      |=> ($stable(accRe) && $stable(accIm))); // R9

  AST_LOAD_PRODUCT: assert property (@(posedge clk) disable iff (rst)
    strobe.accLoad |=> (accRe == $past(sumRe) && accIm == $past(sumIm))); // R6

  AST_ADD_PRODUCT: assert property (@(posedge clk) disable iff (rst)
    strobe.accAdd |=> (accRe == $past(accRe) + $past(sumRe))); // R5

endmodule

// File: rtl/cplx_mac.sv
module cplx_mac
  import cplx_mac_pkg::*;
#(
  parameter  int OP_W  = 18,
  localparam int RES_W = 2 * OP_W + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    inValid,
  input  logic signed [OP_W-1:0]  aRe,
  input  logic signed [OP_W-1:0]  aIm,
  input  logic signed [OP_W-1:0]  bRe,
  input  logic signed [OP_W-1:0]  bIm,
  input  logic                    accClear,
  input  logic                    accEnable,
  output logic                    outValid,
  output logic signed [RES_W-1:0] resRe,
  output logic signed [RES_W-1:0] resIm
);

  macStrobe_t strobe;

  cplx_mac_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .inValid   (inValid),
    .accClear  (accClear),
    .accEnable (accEnable),
    .strobe    (strobe),
    .outValid  (outValid)
  );

  cplx_mac_dp #(.OP_W(OP_W)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .aRe    (aRe),
    .aIm    (aIm),
    .bRe    (bRe),
    .bIm    (bIm),
    .resRe  (resRe),
    .resIm  (resIm)
  );

endmodule

// File: tb/sim_cplx_mac.sv
module sim_cplx_mac;

  localparam int OP_W       = 18;
  localparam int RES_W      = 2 * OP_W + 1;
  localparam int CLK_PERIOD = 10;

  typedef logic signed [OP_W-1:0]  op_t;
  typedef logic signed [RES_W-1:0] res_t;

  localparam op_t OP_MIN = op_t'(1) <<< (OP_W - 1);
  localparam op_t OP_MAX = ~OP_MIN;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0, accClear = 1'b0, accEnable = 1'b0;
  op_t  aRe = '0, aIm = '0, bRe = '0, bIm = '0;
  logic outValid;
  res_t resRe, resIm;

  cplx_mac #(.OP_W(OP_W)) u0 (
    .clk(clk), .rst(rst), .inValid(inValid),
    .aRe(aRe), .aIm(aIm), .bRe(bRe), .bIm(bIm),
    .accClear(accClear), .accEnable(accEnable),
    .outValid(outValid), .resRe(resRe), .resIm(resIm)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // Bench model: a three-deep record of applied inputs plus the expected total.
  logic  pv[3], pclr[3], pen[3];
  op_t   par[3], pai[3], pbr[3], pbi[3];
  string ptag[3];
  res_t  expRe = '0, expIm = '0;
  logic  expV = 1'b0;

  function automatic res_t refRe(op_t ar, op_t ai, op_t br, op_t bi);
    longint x = longint'(ar) * longint'(br) - longint'(ai) * longint'(bi);
    return res_t'(x);
  endfunction

  function automatic res_t refIm(op_t ar, op_t ai, op_t br, op_t bi);
    longint x = longint'(ar) * longint'(bi) + longint'(ai) * longint'(br);
    return res_t'(x);
  endfunction

  task automatic check(string tag, string what, res_t act, res_t exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(logic v, op_t ar, op_t ai, op_t br, op_t bi,
                      logic clr, logic en, string tag);
    string t;
    @(negedge clk);
    inValid = v; aRe = ar; aIm = ai; bRe = br; bIm = bi;
    accClear = clr; accEnable = en;
    @(posedge clk);
    for (int i = 2; i > 0; i--) begin
      pv[i] = pv[i-1]; pclr[i] = pclr[i-1]; pen[i] = pen[i-1];
      par[i] = par[i-1]; pai[i] = pai[i-1]; pbr[i] = pbr[i-1]; pbi[i] = pbi[i-1];
      ptag[i] = ptag[i-1];
    end
    pv[0] = v; pclr[0] = clr; pen[0] = en;
    par[0] = ar; pai[0] = ai; pbr[0] = br; pbi[0] = bi; ptag[0] = tag;
    // Entry 2 reaches the result ports on this edge.
    if (pv[2]) begin
      if (pclr[2])     t = "R6";
      else if (!pen[2]) t = "R4";
      else             t = "R5";
      if (pclr[2] || !pen[2]) begin
        expRe = refRe(par[2], pai[2], pbr[2], pbi[2]);
        expIm = refIm(par[2], pai[2], pbr[2], pbi[2]);
      end else begin
        expRe = expRe + refRe(par[2], pai[2], pbr[2], pbi[2]);
        expIm = expIm + refIm(par[2], pai[2], pbr[2], pbi[2]);
      end
      expV = 1'b1;
    end else if (pclr[2]) begin
      t = "R7"; expRe = '0; expIm = '0; expV = 1'b0;
    end else begin
      t = "R9"; expV = 1'b0;
    end
    if (ptag[2] != "") t = ptag[2];
    #1;
    check("R2", "outValid", res_t'(outValid), res_t'(expV));
    check(t, "resRe", resRe, expRe);
    check(t, "resIm", resIm, expIm);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, '0, '0, '0, '0, 1'b0, 1'b0, "");
  endtask

  function automatic op_t randOp();
    int unsigned s = $urandom % 8;
    if (s == 0) return OP_MIN;
    if (s == 1) return OP_MAX;
    return op_t'($urandom);
  endfunction

  bit done = 1'b0;

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd1357);
    for (int i = 0; i < 3; i++) begin
      pv[i] = 0; pclr[i] = 0; pen[i] = 0; ptag[i] = "";
      par[i] = '0; pai[i] = '0; pbr[i] = '0; pbi[i] = '0;
    end

    // R3: reset state
    inValid = 1'b1; accClear = 1'b1; aRe = OP_MAX; bRe = OP_MAX;
    repeat (5) @(posedge clk);
    #1;
    check("R3", "outValid", res_t'(outValid), '0);
    check("R3", "resRe", resRe, '0);
    check("R3", "resIm", resIm, '0);
    @(negedge clk);
    inValid = 1'b0; accClear = 1'b0; aRe = '0; bRe = '0;
    rst = 1'b0;

    // R1: small mixed-sign product: re = 15+28 = 43, im = 21-20 = 1
    step(1'b1, 18'sd3, -18'sd4, 18'sd5, 18'sd7, 1'b0, 1'b0, "R1");
    idle(3);
    check("R1", "directed re", expRe, res_t'(43));
    check("R1", "directed im", expIm, res_t'(1));

    // R10: most negative value in every part
    step(1'b1, OP_MIN, OP_MIN, OP_MIN, OP_MIN, 1'b0, 1'b1, "R10");
    step(1'b1, OP_MIN, OP_MIN, OP_MIN, OP_MIN, 1'b1, 1'b0, "R10");
    idle(3);
    check("R10", "model im", expIm, res_t'(longint'(1) <<< (2*OP_W-1)));

    // R5 chain, R6 restart, R7 zeroing, R9 hold
    step(1'b1, randOp(), randOp(), randOp(), randOp(), 1'b1, 1'b1, "");
    for (int i = 0; i < 12; i++)
      step(1'b1, randOp(), randOp(), randOp(), randOp(), 1'b0, 1'b1, "");
    step(1'b1, randOp(), randOp(), randOp(), randOp(), 1'b1, 1'b1, "");
    idle(4);
    step(1'b0, '0, '0, '0, '0, 1'b1, 1'b0, "");
    idle(4);

    // R8: repeated near-maximum real products overflow the total
    step(1'b1, OP_MIN, OP_MIN, OP_MIN, OP_MAX, 1'b1, 1'b1, "R8");
    for (int i = 0; i < 9; i++)
      step(1'b1, OP_MIN, OP_MIN, OP_MIN, OP_MAX, 1'b0, 1'b1, "R8");
    idle(3);

    // Mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      logic v, c, e;
      v = ($urandom % 4) != 0;
      c = ($urandom % 10) == 0;
      e = ($urandom % 5) != 0;
      step(v, randOp(), randOp(), randOp(), randOp(), c, e, "");
    end
    idle(4);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule